// File: doc/BRIEF.md
# Comma-Locked Receive Character Aligner

This block sits behind a deserializer that hands over ten received bits per beat with an arbitrary phase. It searches the stream for the seven-bit synchronisation comma and moves the character boundary so that each comma begins at bit 0 of an output character. The block then issues characters on that boundary. Each character carries a phase tag, and the tags alternate so that characters can be steered onto two half-rate lanes. A status output reports commas seen on the settled boundary, and it changes only when an even-lane character is issued. An enable input allows or freezes realignment.

Both the input and the output of the data path use valid/ready handshakes. The input is accepted only when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the presented character, its phase tag and the status outputs hold. The source must also hold `in_data` steady until the word is accepted. All state advances only on an accepted word.

Top module: `comma_aligner`

## Requirements
- R1: After reset `out_valid`, `comma_det`, `aligned` and `boundary` are all 0.
- R2: The comma is seven consecutive received bits. Counting from the earliest bit, they are 0,0,1,1,1,1,1, which is 7'b1111100 with bit 0 first. The search covers the 20 bits made of the previous accepted word (bits 0-9) and the current one (bits 10-19). Every start offset from 0 to 9 is searched, and when several offsets match, the lowest one wins.
- R3: With `align_en` high, a comma found at an offset moves `boundary` to that offset. The character built from the same accepted word already uses the new offset, so its bits [6:0] equal 7'b1111100.
- R4: While `align_en` is low, `boundary` and `aligned` do not change, whatever the data.
- R5: `boundary` holds its value until a comma is found at a different offset with `align_en` high.
- R6: `aligned` becomes 1 the first time a comma is found with `align_en` high, and it stays 1 until reset.
- R7: Each output character is the ten window bits that start at the boundary in force for that word, with the earliest bit at bit 0.
- R8: `out_phase` is 1 for the first character after reset and toggles with every issued character. Characters 0 and 2 of each group of four are tagged 1, and characters 1 and 3 are tagged 0.
- R9: `comma_det` changes only when a phase-1 character is issued. It is then set to whether a comma was reported for that character or for the phase-0 character just before it.
- R10: A comma is reported when `align_en` is high. It is also reported when `align_en` is low, the block is aligned, and the comma lies exactly on the current boundary. With `align_en` low and the block not aligned, a comma is not reported.
- R11: `in_ready` equals `!out_valid || out_ready`. A stalled output keeps `out_valid` and `out_char` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_en | input | 1 | Allows boundary realignment |
| in_valid | input | 1 | Received word present |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 10 | Received bits, bit 0 earliest |
| out_ready | input | 1 | Consumer takes the character |
| out_valid | output | 1 | Character presented |
| out_char | output | 10 | Aligned character, bit 0 earliest |
| out_phase | output | 1 | Lane tag: 1 for characters 0 and 2, 0 for characters 1 and 3 |
| comma_det | output | 1 | Comma reported in the last character pair |
| aligned | output | 1 | A realignment has happened since reset |
| boundary | output | 4 | Current character start offset |

## Verification
The assertions assume that `in_data` does not change while a word waits for acceptance. They also assume that `align_en` is sampled only at clock edges, so a boundary change can be traced to an accepted word. The stimulus holds each word until the handshake completes, and it changes `align_en` only between clock edges, on the falling edge. Directed segments build the bit stream from an alternating filler that contains no pair of zeros, so no comma can form except where one is placed on purpose. Random segments mix free bits, planted commas and random stalls on both sides of the block.

// File: rtl/cda_pkg.sv
package cda_pkg;
  // Lane tag of a presented character.
  typedef enum logic {
    LANE_ODD  = 1'b0,
    LANE_EVEN = 1'b1
  } lane_e;

  function automatic lane_e lane_flip(input lane_e cur);
    return (cur == LANE_ODD) ? LANE_EVEN : LANE_ODD;
  endfunction
endpackage

// File: rtl/cda_scan.sv
module cda_scan #(
  parameter int CHAR_W = 10,
  parameter int MARK_W = 7,
  parameter logic [MARK_W-1:0] MARK = 7'b1111100,
  localparam int WIN_W = 2 * CHAR_W,
  localparam int OFF_W = $clog2(CHAR_W)
) (
  input  logic [WIN_W-1:0]  win_i,
  output logic [CHAR_W-1:0] match_o,
  output logic              any_o,
  output logic [OFF_W-1:0]  first_o
);
  // One comparator per candidate start offset.
  for (genvar g = 0; g < CHAR_W; g++) begin : g_cmp
    assign match_o[g] = (win_i[g +: MARK_W] == MARK);
  end

  // Lowest matching offset wins (R2).
  always_comb begin
    any_o   = 1'b0;
    first_o = '0;
    for (int i = CHAR_W - 1; i >= 0; i--) begin
      if (match_o[i]) begin
        any_o   = 1'b1;
        first_o = OFF_W'(i);
      end
    end
  end
endmodule

// File: rtl/cda_ctrl.sv
module cda_ctrl #(
  parameter int CHAR_W = 10,
  localparam int OFF_W = $clog2(CHAR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic              en_i,
  input  logic [CHAR_W-1:0] match_i,
  input  logic              any_i,
  input  logic [OFF_W-1:0]  first_i,
  output logic [OFF_W-1:0]  off_o,
  output logic [OFF_W-1:0]  sel_o,
  output logic              aligned_o,
  output logic              det_ev_o
);
  logic [OFF_W-1:0] off_q;
  logic             aligned_q;

  // The new offset applies to the word that carried the comma (R3).
  assign sel_o    = (en_i && any_i) ? first_i : off_q;
  assign det_ev_o = any_i && (en_i || (aligned_q && match_i[off_q]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q     <= '0;
      aligned_q <= 1'b0;
    end else if (acc_i) begin
      off_q <= sel_o;
      if (en_i && any_i) aligned_q <= 1'b1;
    end
  end

  assign off_o     = off_q;
  assign aligned_o = aligned_q;

  a_r4_frozen_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(off_q) && $stable(aligned_q)));
  a_r5_boundary_held_without_comma: assert property (@(posedge clk) disable iff (!rst_n)
    !any_i |=> $stable(off_q));
  a_r6_aligned_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aligned_q |=> aligned_q);
endmodule

// File: rtl/cda_emit.sv
module cda_emit
  import cda_pkg::*;
#(
  parameter int CHAR_W = 10,
  localparam int WIN_W = 2 * CHAR_W,
  localparam int OFF_W = $clog2(CHAR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic              out_ready_i,
  input  logic [WIN_W-1:0]  win_i,
  input  logic [OFF_W-1:0]  sel_i,
  input  logic              det_ev_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [CHAR_W-1:0] out_char_o,
  output logic              out_phase_o,
  output logic              comma_det_o
);
  logic              valid_q;
  logic [CHAR_W-1:0] char_q;
  lane_e             lane_q;
  lane_e             lane_n;
  logic              pend_q;
  logic              det_q;

  assign in_ready_o = !valid_q || out_ready_i;
  assign lane_n     = lane_flip(lane_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      char_q  <= '0;
      lane_q  <= LANE_ODD;
      pend_q  <= 1'b0;
      det_q   <= 1'b0;
    end else if (acc_i) begin
      valid_q <= 1'b1;
      char_q  <= win_i[sel_i +: CHAR_W];
      lane_q  <= lane_n;
      if (lane_n == LANE_EVEN) begin
        det_q  <= det_ev_i || pend_q;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_q || det_ev_i;
      end
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_char_o  = char_q;
  assign out_phase_o = lane_q;
  assign comma_det_o = det_q;

  a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready_i) |=> (valid_q && $stable(char_q)));
  a_r9_det_rises_on_even: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_q) |-> (lane_q == LANE_EVEN && valid_q));
  a_r8_lane_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |=> (lane_q != $past(lane_q)));
  a_r8_lane_still_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i |=> ($stable(lane_q) && $stable(det_q)));
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int CHAR_W = 10,
  parameter int MARK_W = 7,
  parameter logic [MARK_W-1:0] MARK = 7'b1111100,
  localparam int WIN_W = 2 * CHAR_W,
  localparam int OFF_W = $clog2(CHAR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              align_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  output logic              out_phase,
  output logic              comma_det,
  output logic              aligned,
  output logic [OFF_W-1:0]  boundary
);
  logic [CHAR_W-1:0] prev_q;
  logic [WIN_W-1:0]  win;
  logic              acc;
  logic [CHAR_W-1:0] match;
  logic              any_hit;
  logic [OFF_W-1:0]  first_off;
  logic [OFF_W-1:0]  sel_off;
  logic              det_ev;

  assign acc = in_valid && in_ready;
  assign win = {in_data, prev_q};

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else if (acc) prev_q <= in_data;
  end

  cda_scan #(.CHAR_W(CHAR_W), .MARK_W(MARK_W), .MARK(MARK)) u_scan (
    .win_i   (win),
    .match_o (match),
    .any_o   (any_hit),
    .first_o (first_off)
  );

  cda_ctrl #(.CHAR_W(CHAR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_i     (acc),
    .en_i      (align_en),
    .match_i   (match),
    .any_i     (any_hit),
    .first_i   (first_off),
    .off_o     (boundary),
    .sel_o     (sel_off),
    .aligned_o (aligned),
    .det_ev_o  (det_ev)
  );

  cda_emit #(.CHAR_W(CHAR_W)) u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (acc),
    .out_ready_i (out_ready),
    .win_i       (win),
    .sel_i       (sel_off),
    .det_ev_i    (det_ev),
    .in_ready_o  (in_ready),
    .out_valid_o (out_valid),
    .out_char_o  (out_char),
    .out_phase_o (out_phase),
    .comma_det_o (comma_det)
  );
endmodule

// File: tb/comma_aligner_bench.sv
module comma_aligner_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       align_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_data = '0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [9:0] out_char;
  logic       out_phase;
  logic       comma_det;
  logic       aligned;
  logic [3:0] boundary;

  always #5 clk = ~clk;

  comma_aligner u_comma_aligner (
    .clk(clk), .rst_n(rst_n), .align_en(align_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_char(out_char), .out_phase(out_phase),
    .comma_det(comma_det), .aligned(aligned), .boundary(boundary)
  );

  localparam logic [6:0] COMMA = 7'b1111100;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // stream source
  bit bq[$];
  int pushed = 0;
  bit last_bit = 0;
  bit en_mode = 0;
  bit have = 0;
  logic [9:0] cur = '0;

  // reference state
  logic [9:0] m_prev = '0;
  int  m_off = 0;
  bit  m_al = 0, m_pend = 0, m_det = 0, m_ph = 0, exp_valid = 0;
  logic [9:0] exp_char = '0;

  // observation
  int  rises = 0;
  bit  last_det = 0, comma_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_bit(input bit b);
    bq.push_back(b);
    pushed++;
    last_bit = b;
  endtask

  task automatic push_filler(input int n);
    for (int i = 0; i < n; i++) push_bit(!last_bit);
  endtask

  task automatic push_comma();
    for (int i = 0; i < 7; i++) push_bit(COMMA[i]);
  endtask

  task automatic pad_to(input int k);
    while ((pushed % 10) != k) push_filler(1);
  endtask

  task automatic pop_word(output logic [9:0] w);
    if (bq.size() < 10) push_filler(10);
    for (int i = 0; i < 10; i++) w[i] = bq.pop_front();
  endtask

  task automatic model(input logic [9:0] d);
    logic [19:0] win;
    int hit;
    bit onb, ev;
    win = {d, m_prev};
    hit = -1;
    for (int o = 0; o < 10; o++)
      if (hit < 0 && win[o +: 7] == COMMA) hit = o;
    onb = (win[m_off +: 7] == COMMA);
    ev  = (hit >= 0) && (en_mode || (m_al && onb));
    if (en_mode && hit >= 0) begin
      m_off = hit;
      m_al  = 1;
    end
    exp_char = win[m_off +: 10];
    m_prev = d;
    m_ph = !m_ph;
    if (m_ph) begin
      m_det  = ev || m_pend;
      m_pend = 0;
    end else begin
      m_pend = m_pend || ev;
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(out_valid == exp_valid, "R11 out_valid", out_valid, exp_valid);
    if (exp_valid) begin
      chk(out_char == exp_char, "R7 out_char", out_char, exp_char);
      chk(out_phase == m_ph, "R8 out_phase", out_phase, m_ph);
    end
    chk(comma_det == m_det, "R9 comma_det", comma_det, m_det);
    chk(boundary == 4'(m_off), "R5 boundary", boundary, m_off);
    chk(aligned == m_al, "R6 aligned", aligned, m_al);
    if (comma_det && !last_det) rises++;
    last_det = comma_det;
    if (out_valid && out_char[6:0] == COMMA) comma_seen = 1;
    out_ready = ($urandom % 4) != 0;
    if (!have && ($urandom % 5) != 0) begin
      pop_word(cur);
      have = 1;
    end
    in_valid = have;
    in_data  = cur;
    align_en = en_mode;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R11 in_ready", in_ready, !out_valid || out_ready);
    if (in_valid && in_ready) begin
      model(cur);
      have = 0;
      exp_valid = 1;
    end else if (out_ready) begin
      exp_valid = 0;
    end
  endtask

  task automatic run(input int n);
    rises = 0;
    comma_seen = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(comma_det == 0, "R1 comma_det", comma_det, 0);
    chk(aligned == 0, "R1 aligned", aligned, 0);
    chk(boundary == 0, "R1 boundary", boundary, 0);
    rst_n = 1'b1;

    // R10: disabled and not aligned, comma on boundary 0 is not reported
    en_mode = 0;
    push_filler(20); pad_to(0); push_comma(); push_filler(40);
    run(60);
    chk(rises == 0, "R10 unaligned disabled no report", rises, 0);
    chk(aligned == 0, "R4 aligned stays low", aligned, 0);

    // R3: enabled, comma at offset 3 realigns
    en_mode = 1;
    pad_to(3); push_comma(); push_filler(40);
    run(60);
    chk(boundary == 3, "R3 boundary moved", boundary, 3);
    chk(comma_seen == 1, "R3 comma at bit 0", comma_seen, 1);
    chk(aligned == 1, "R6 aligned set", aligned, 1);
    chk(rises == 1, "R10 enabled comma reported", rises, 1);

    // R4: disabled, comma at offset 8 ignored and not reported
    en_mode = 0;
    pad_to(8); push_comma(); push_filler(40);
    run(60);
    chk(boundary == 3, "R4 boundary frozen", boundary, 3);
    chk(rises == 0, "R10 off-boundary comma not reported", rises, 0);

    // R10: disabled, aligned, comma on the boundary is reported
    pad_to(3); push_comma(); push_filler(40);
    run(60);
    chk(rises == 1, "R10 on-boundary comma reported", rises, 1);
    chk(comma_seen == 1, "R7 aligned comma output", comma_seen, 1);

    // R5: enabled, comma again at 3 keeps the boundary
    en_mode = 1;
    pad_to(3); push_comma(); push_filler(40);
    run(60);
    chk(boundary == 3, "R5 boundary kept", boundary, 3);

    // R2: two commas in one window, lowest offset wins (offsets 1 and 8)
    pad_to(1); push_comma(); push_comma(); push_filler(40);
    run(60);
    chk(boundary == 1, "R2 lowest offset", boundary, 1);

    // random segments with planted commas and enable toggling
    for (int seg = 0; seg < 10; seg++) begin
      en_mode = ($urandom % 2) != 0;
      for (int c = 0; c < 200; c++) begin
        if (bq.size() < 20) begin
          if (($urandom % 6) == 0) push_comma();
          else for (int b = 0; b < 10; b++) push_bit(1'($urandom % 2));
        end
        step();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule